// File: doc/BRIEF.md
# Single-Cycle Register/Memory Datapath

This block is the execution half of a 32-bit processor that finishes one instruction per clock. A decoder outside it supplies the instruction word and a small set of control lines; in the same cycle the block reads two source registers, optionally swaps the second one for an extended 16-bit immediate, runs the ALU, optionally reads or writes a word of data memory, and on the next rising edge commits the result to the register file. It covers register-register ALU operations, logical operations with an immediate, word loads and word stores.

The register file has 32 entries of 32 bits, with two combinational read ports and one write port. Entry 0 is hard-wired to zero. The data memory is a small word array indexed by ALU result bits, with a combinational read so that a load completes inside its own cycle. A comparator on the two register read buses drives an equality flag for use by an external branch unit. The value about to be written back is also driven out, so that the results can be observed.

Top module: `sc_datapath`

## Requirements
- R1: Instruction fields are rs = bits 25:21, rt = bits 20:16, rd = bits 15:11 and immediate = bits 15:0. Read port A is addressed by rs and read port B by rt.
- R2: With `reg_dst_i`=1 the write address is rd; with 0 it is rt.
- R3: A register changes only on a rising clock edge with `reg_wr_i`=1. With `reg_wr_i`=0 the register file is left unchanged.
- R4: Register 0 always reads as zero. A write addressed to it has no effect.
- R5: With `ext_sign_i`=0 the immediate is zero-extended (upper 16 bits 0). With 1 it is sign-extended from bit 15.
- R6: With `alu_src_i`=0 the second ALU operand is read port B; with 1 it is the extended immediate.
- R7: `alu_ctl_i` codes are 000 add, 001 subtract (A minus B), 010 bitwise OR and 011 bitwise AND, all modulo 2^32. Every other code yields 0.
- R8: With `mem_wr_i`=1, the rising edge stores read port B into the word indexed by ALU result bits [MEM_AW+1:2]. With `mem_wr_i`=0 the memory is unchanged.
- R9: With `mem_to_reg_i`=1 the write-back value is the memory word at the current ALU-result index, available in the same cycle. With 0 it is the ALU result.
- R10: `equal_o` is 1 exactly when read port A equals read port B.
- R11: `wb_data_o` always shows the write-back value. An active-low asynchronous reset clears all registers and all memory words to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all storage updates on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset of register file and memory |
| instr_i | input | 32 | Instruction word |
| reg_dst_i | input | 1 | Write-address select: 0 rt, 1 rd |
| reg_wr_i | input | 1 | Register write enable |
| alu_src_i | input | 1 | Second operand select: 0 register, 1 immediate |
| alu_ctl_i | input | 3 | ALU operation code |
| ext_sign_i | input | 1 | Immediate extension: 0 zero, 1 sign |
| mem_wr_i | input | 1 | Data memory write enable |
| mem_to_reg_i | input | 1 | Write-back select: 0 ALU, 1 memory |
| wb_data_o | output | 32 | Value on the register write-back bus |
| equal_o | output | 1 | Read port A equals read port B |

## Verification
The hardest case to reach is a load whose address depends on sign extension: a positive base register plus a negative offset has to wrap across 2^32 to land on a small word index that a store filled earlier. Only a sequence can set this up. First, registers are built from immediates. Next, a store goes to one address. Last, a load reaches that same word through a base of 0x8001 and an offset of 0x8007, then a later add reads the loaded register back. The same chained vector table also covers a disabled store followed by a reload, and a write aimed at register 0 followed by a read of it.

// File: rtl/scdp_pkg.sv
package scdp_pkg;

  localparam int unsigned DATA_W = 32;
  localparam int unsigned REG_AW = 5;
  localparam int unsigned IMM_W  = 16;
  localparam int unsigned CTL_W  = 3;

  typedef enum logic [CTL_W-1:0] {
    OP_ADD = 3'b000,
    OP_SUB = 3'b001,
    OP_OR  = 3'b010,
    OP_AND = 3'b011
  } alu_code_e;

  // ALU arithmetic; undefined codes give zero
  function automatic logic [DATA_W-1:0] alu_eval(
    input logic [CTL_W-1:0]  code,
    input logic [DATA_W-1:0] a,
    input logic [DATA_W-1:0] b
  );
    logic [DATA_W-1:0] y;
    case (code)
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_OR:   y = a | b;
      OP_AND:  y = a & b;
      default: y = '0;
    endcase
    return y;
  endfunction

  // immediate widening to data width
  function automatic logic [DATA_W-1:0] widen_imm(
    input logic [IMM_W-1:0] imm,
    input logic             as_signed
  );
    logic fill;
    fill = as_signed & imm[IMM_W-1];
    return {{(DATA_W-IMM_W){fill}}, imm};
  endfunction

endpackage

// File: rtl/sc_regfile.sv
module sc_regfile
  import scdp_pkg::*;
#(
  parameter int unsigned AW = REG_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     ra_a_i,
  input  logic [AW-1:0]     ra_b_i,
  output logic [DATA_W-1:0] rd_a_o,
  output logic [DATA_W-1:0] rd_b_o,
  input  logic              we_i,
  input  logic [AW-1:0]     wa_i,
  input  logic [DATA_W-1:0] wd_i
);
  localparam int unsigned NREG = 1 << AW;

  logic [DATA_W-1:0] regs_q [NREG];
  logic [NREG-1:0]   wsel;

  // one-hot write decode, entry 0 masked off
  always_comb begin
    wsel = '0;
    if (we_i) wsel[wa_i] = 1'b1;
    wsel[0] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else begin
      for (int i = 0; i < NREG; i++)
        if (wsel[i]) regs_q[i] <= wd_i;
    end
  end

  assign rd_a_o = regs_q[ra_a_i];
  assign rd_b_o = regs_q[ra_b_i];

  // R4
  r0_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    regs_q[0] == '0);

  // R3
  wsel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wsel) && (we_i || wsel == '0));

  // R3
  rf_writeback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && wa_i != '0) |=> (ra_a_i != $past(wa_i)) || (rd_a_o == $past(wd_i)));

endmodule

// File: rtl/sc_imm_ext.sv
module sc_imm_ext
  import scdp_pkg::*;
(
  input  logic [IMM_W-1:0]  imm_i,
  input  logic              sign_i,
  output logic [DATA_W-1:0] ext_o
);
  assign ext_o = widen_imm(imm_i, sign_i);
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import scdp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTL_W-1:0]  code_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] y_o
);
  logic code_known;

  assign y_o        = alu_eval(code_i, a_i, b_i);
  assign code_known = (code_i == OP_ADD) || (code_i == OP_SUB) ||
                      (code_i == OP_OR)  || (code_i == OP_AND);

  // R7
  alu_unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !code_known |-> (y_o == '0));

endmodule

// File: rtl/sc_dmem.sv
module sc_dmem
  import scdp_pkg::*;
#(
  parameter int unsigned MEM_AW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [DATA_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned NWORD = 1 << MEM_AW;
  localparam int unsigned LSB   = 2;

  logic [DATA_W-1:0] words_q [NWORD];
  logic [MEM_AW-1:0] idx;
  logic              unused_addr;

  assign idx         = addr_i[MEM_AW+LSB-1:LSB];
  assign unused_addr = ^{addr_i[DATA_W-1:MEM_AW+LSB], addr_i[LSB-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NWORD; i++) words_q[i] <= '0;
    end else if (we_i) begin
      words_q[idx] <= wdata_i;
    end
  end

  assign rdata_o = words_q[idx];

  // R8
  mem_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> (idx != $past(idx)) || (rdata_o == $past(wdata_i)));

  // R8
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> (idx != $past(idx)) || $stable(rdata_o));

endmodule

// File: rtl/sc_datapath.sv
module sc_datapath
  import scdp_pkg::*;
#(
  parameter int unsigned MEM_AW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       instr_i,
  input  logic              reg_dst_i,
  input  logic              reg_wr_i,
  input  logic              alu_src_i,
  input  logic [2:0]        alu_ctl_i,
  input  logic              ext_sign_i,
  input  logic              mem_wr_i,
  input  logic              mem_to_reg_i,
  output logic [31:0]       wb_data_o,
  output logic              equal_o
);
  logic [REG_AW-1:0] f_rs, f_rt, f_rd, wr_addr;
  logic [IMM_W-1:0]  f_imm;
  logic [DATA_W-1:0] bus_a, bus_b, ext_imm, opnd_b, alu_y, mem_q, bus_w;
  logic              unused_opc;

  // instruction fields
  assign f_rs       = instr_i[25:21];
  assign f_rt       = instr_i[20:16];
  assign f_rd       = instr_i[15:11];
  assign f_imm      = instr_i[15:0];
  assign unused_opc = ^instr_i[31:26];

  assign wr_addr = reg_dst_i ? f_rd : f_rt;

  sc_regfile #(.AW(REG_AW)) u_rf (
    .clk    (clk),
    .rst_n  (rst_n),
    .ra_a_i (f_rs),
    .ra_b_i (f_rt),
    .rd_a_o (bus_a),
    .rd_b_o (bus_b),
    .we_i   (reg_wr_i),
    .wa_i   (wr_addr),
    .wd_i   (bus_w)
  );

  sc_imm_ext u_ext (
    .imm_i  (f_imm),
    .sign_i (ext_sign_i),
    .ext_o  (ext_imm)
  );

  assign opnd_b = alu_src_i ? ext_imm : bus_b;

  sc_alu u_alu (
    .clk    (clk),
    .rst_n  (rst_n),
    .code_i (alu_ctl_i),
    .a_i    (bus_a),
    .b_i    (opnd_b),
    .y_o    (alu_y)
  );

  sc_dmem #(.MEM_AW(MEM_AW)) u_mem (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (mem_wr_i),
    .addr_i  (alu_y),
    .wdata_i (bus_b),
    .rdata_o (mem_q)
  );

  assign bus_w     = mem_to_reg_i ? mem_q : alu_y;
  assign wb_data_o = bus_w;
  assign equal_o   = (bus_a == bus_b);

  // R5
  ext_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_sign_i |-> (ext_imm[DATA_W-1:IMM_W] == '0));

  // R5
  ext_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_sign_i && instr_i[15]) |-> (ext_imm[DATA_W-1:IMM_W] == '1));

  // R6
  opnd_imm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alu_src_i |-> (opnd_b[IMM_W-1:0] == instr_i[15:0]));

endmodule

// File: tb/sc_datapath_tb.sv
module sc_datapath_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 20;
  localparam int VW = 82;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] instr = '0;
  logic        reg_dst = 0, reg_wr = 0, alu_src = 0, ext_sign = 0, mem_wr = 0, mem_to_reg = 0;
  logic [2:0]  alu_ctl = '0;
  logic [31:0] wb_data;
  logic        equal;
  int          n_checks = 0;
  int          n_errors = 0;

  sc_datapath u_dut (
    .clk(clk), .rst_n(rst_n), .instr_i(instr), .reg_dst_i(reg_dst),
    .reg_wr_i(reg_wr), .alu_src_i(alu_src), .alu_ctl_i(alu_ctl),
    .ext_sign_i(ext_sign), .mem_wr_i(mem_wr), .mem_to_reg_i(mem_to_reg),
    .wb_data_o(wb_data), .equal_o(equal)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] ity(int rs, int rt, logic [15:0] imm);
    return {6'd0, rs[4:0], rt[4:0], imm};
  endfunction
  function automatic logic [31:0] rty(int rs, int rt, int rd);
    return {6'd0, rs[4:0], rt[4:0], rd[4:0], 11'd0};
  endfunction
  // ctrl = {reg_dst, reg_wr, alu_src, alu_ctl[2:0], ext_sign, mem_wr, mem_to_reg}
  function automatic logic [8:0] cr(logic [2:0] op, logic wr);
    return {1'b1, wr, 1'b0, op, 3'b000};
  endfunction
  localparam logic [8:0] C_ORI  = 9'b0_1_1_010_0_0_0;
  localparam logic [8:0] C_ADDI = 9'b0_1_1_000_1_0_0;
  localparam logic [8:0] C_LW   = 9'b0_1_1_000_1_0_1;
  localparam logic [8:0] C_SW   = 9'b0_0_1_000_1_1_0;
  localparam logic [8:0] C_IDLE = 9'b0_0_1_000_1_0_0;

  function automatic logic [VW-1:0] v(int req, logic [31:0] ins, logic [8:0] c,
                                       logic [31:0] wb, logic eq);
    return {req[7:0], ins, c, wb, eq};
  endfunction

  localparam logic [VW-1:0] VEC [NVEC] = '{
    v(5,  ity(0,1,16'h8001),  C_ORI,        32'h00008001, 1'b1), // R5 zero ext
    v(5,  ity(0,2,16'h8001),  C_ADDI,       32'hFFFF8001, 1'b1), // R5 sign ext, R6
    v(7,  rty(1,2,3),         cr(3'd0,1),   32'h00000002, 1'b0), // R7 add wraps, R2 rd
    v(7,  rty(1,2,4),         cr(3'd1,1),   32'h00010000, 1'b0), // R7 sub
    v(7,  rty(1,2,5),         cr(3'd2,1),   32'hFFFF8001, 1'b0), // R7 or
    v(7,  rty(1,2,6),         cr(3'd3,1),   32'h00008001, 1'b0), // R7 and
    v(7,  rty(1,2,7),         cr(3'd7,1),   32'h00000000, 1'b0), // R7 unused code
    v(4,  ity(1,0,16'h00FF),  C_ORI,        32'h000080FF, 1'b0), // R4 write to r0
    v(4,  rty(0,0,8),         cr(3'd0,1),   32'h00000000, 1'b1), // R4 r0 still zero
    v(8,  ity(3,4,16'h0006),  C_SW,         32'h00000008, 1'b0), // R8 store r4 at word 2
    v(8,  ity(0,5,16'h0004),  C_SW,         32'h00000004, 1'b0), // R8 store r5 at word 1
    v(9,  ity(1,9,16'h8007),  C_LW,         32'h00010000, 1'b0), // R9 load, negative offset
    v(9,  ity(0,10,16'h0004), C_LW,         32'hFFFF8001, 1'b1), // R9 load word 1
    v(10, rty(2,10,11),       cr(3'd0,1),   32'hFFFF0002, 1'b1), // R10 equal regs
    v(2,  rty(9,0,12),        cr(3'd0,1),   32'h00010000, 1'b0), // R2 load wrote rt, R1
    v(6,  ity(7,13,16'h0000), C_ORI,        32'h00000000, 1'b1), // R6 R7 result stored 0
    v(8,  ity(0,1,16'h0004),  C_IDLE,       32'h00000004, 1'b0), // R8 mem_wr low
    v(8,  ity(0,14,16'h0004), C_LW,         32'hFFFF8001, 1'b1), // R8 word 1 unchanged
    v(3,  rty(1,1,15),        cr(3'd0,0),   32'h00010002, 1'b1), // R3 no write
    v(3,  rty(15,0,16),       cr(3'd0,1),   32'h00000000, 1'b1)  // R3 r15 still zero
  };

  task automatic check(string req, logic [31:0] exp_wb, logic exp_eq);
    n_checks++;
    if (wb_data !== exp_wb || equal !== exp_eq) begin
      n_errors++;
      $display("FAIL %s: wb=%h eq=%b expected wb=%h eq=%b", req, wb_data, equal, exp_wb, exp_eq);
    end
  endtask

  task automatic apply(logic [31:0] ins, logic [8:0] c);
    @(negedge clk);
    instr = ins;
    {reg_dst, reg_wr, alu_src, alu_ctl, ext_sign, mem_wr, mem_to_reg} = c;
    #2;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 100000);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R11 reset state: registers read zero
    apply(rty(5,6,0), cr(3'd0,0));
    check("R11", 32'h0, 1'b1);

    for (int i = 0; i < NVEC; i++) begin
      logic [VW-1:0] e;
      e = VEC[i];
      apply(e[73:42], e[41:33]);
      check($sformatf("R%0d vec%0d", e[81:74], i), e[32:1], e[0]);
    end

    // R11 reset clears registers and memory mid-run
    @(negedge clk) rst_n = 1'b0;
    #2;
    @(negedge clk) rst_n = 1'b1;
    apply(rty(1,0,0), cr(3'd0,0));
    check("R11 reg cleared", 32'h0, 1'b1);
    apply(ity(0,0,16'h0004), 9'b0_0_1_000_1_0_1);
    check("R11 mem cleared", 32'h0, 1'b1);
    // R1 rd field overlaps immediate: ALU ignores it with alu_src=0
    apply(rty(0,0,31), cr(3'd2,0));
    check("R1 R6 rd not operand", 32'h0, 1'b1);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule